// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block runs one 10-bit successive-approximation conversion at a time against an external comparator. Software controls it through one small register holding an enable bit, a reference-select bit, a start bit and a channel field. The block picks one of four ground-referenced inputs through an external 4-way multiplexer and passes the reference choice (supply or internal nominal 1.1 V) to the analog side. It holds the sample-and-hold in track mode for one prescaled tick, then tries one bit per tick from MSB to LSB. It ends with the 10-bit result and a one-clock completion pulse.

The multiplexer and reference selections reach the analog side only while the converter is enabled and idle. A channel change written during a conversion waits until that conversion ends. Clearing the enable bit stops a running conversion at once, with no result and no pulse.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, the read-back register is all zero, and `done`, `sh_track`, `mux_sel`, `ref_sel` and `dac_code` are all zero.
- R2: The register uses these bit positions: bit 0 is enable, bit 1 is reference select, bit 2 is start, and bits 4:3 are the channel. With `cmp_in` high whenever the selected input is at or above `dac_code`, the result equals the input's code (0 means ground, 1023 means full reference).
- R3: Bits are decided from MSB to LSB. The first trial code after the sample phase is 512, and `dac_code` is 0 outside the bit phases.
- R4: `done` goes high for exactly one clock, 11×DIV clocks after the clock edge that accepts the start write. `result` holds the new value in that same cycle.
- R5: The start bit reads 1 from the accepting edge until `done` and reads 0 from then on.
- R6: Writing 0 to the start bit has no effect. An idle block stays idle, and a running conversion continues when enable is kept at 1.
- R7: A channel written during a conversion does not reach `mux_sel` until the conversion ends. The conversion finishes on the old channel, and the next conversion uses the new one.
- R8: While enable is 0, a start write is ignored (start reads 0 and no conversion runs), and channel or reference writes do not reach `mux_sel` or `ref_sel`.
- R9: Writing enable 0 during a conversion aborts it. Start reads 0 on the next cycle, and no `done` pulse follows.
- R10: When enabled and idle, `ref_sel` follows the reference bit, and a conversion measures against the selected reference.
- R11: `sh_track` is high for exactly DIV clocks, starting at the accepting edge, and is never high outside a conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | CH_BITS+3 | Write data: {channel, start, ref, enable} |
| reg_rdata | output | CH_BITS+3 | Read-back of the same fields, start showing busy |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the trial level |
| mux_sel | output | CH_BITS | Applied multiplexer channel |
| ref_sel | output | 1 | Applied reference: 0 supply, 1 internal 1.1 V |
| sh_track | output | 1 | Sample-and-hold track control |
| dac_code | output | RES_BITS | Trial code to the DAC |
| result | output | RES_BITS | Last completed conversion |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench builds the block with RES_BITS=10, CH_BITS=2 and DIV=3. The odd prescale ratio shows whether the tick counter restarts cleanly at each start. The short 33-clock conversion leaves room for many random conversions on all four channels and both references, including codes 0 and 1023. The small ratio also makes it quick to reach writes landing in the sample phase, in the middle of the bit phases and on the final decision tick.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_BITS   = 2'd2
  } sar_state_e;

  localparam int unsigned FLD_EN    = 0;
  localparam int unsigned FLD_REF   = 1;
  localparam int unsigned FLD_START = 2;
  localparam int unsigned FLD_CH_LO = 3;
endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  assign tick   = run && (cnt_q == LAST);
  assign cnt_en = clr || run;

  always_comb begin
    if (clr)       cnt_n = '0;
    else if (tick) cnt_n = '0;
    else           cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end
endmodule

// File: rtl/sar_cfg_regs.sv
module sar_cfg_regs
  import sar_pkg::*;
#(
  parameter int unsigned CH_BITS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [CH_BITS+2:0] reg_wdata,
  input  logic               busy,
  output logic [CH_BITS+2:0] reg_rdata,
  output logic [CH_BITS-1:0] mux_sel,
  output logic               ref_sel,
  output logic               go,
  output logic               abort
);
  logic               en_q, ref_q;
  logic [CH_BITS-1:0] ch_q;
  logic [CH_BITS-1:0] mux_q, mux_n;
  logic               refa_q, refa_n;
  logic               app_en;

  logic               w_en, w_ref, w_start;
  logic [CH_BITS-1:0] w_ch;

  assign w_en    = reg_wdata[FLD_EN];
  assign w_ref   = reg_wdata[FLD_REF];
  assign w_start = reg_wdata[FLD_START];
  assign w_ch    = reg_wdata[FLD_CH_LO +: CH_BITS];

  assign go    = reg_we && w_en && w_start && !busy;
  assign abort = reg_we && !w_en && busy;

  always_comb begin
    app_en = 1'b0;
    mux_n  = mux_q;
    refa_n = refa_q;
    if (go) begin
      app_en = 1'b1;
      mux_n  = w_ch;
      refa_n = w_ref;
    end else if (en_q && !busy) begin
      app_en = 1'b1;
      mux_n  = ch_q;
      refa_n = ref_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ref_q <= 1'b0;
      ch_q  <= '0;
    end else if (reg_we) begin
      en_q  <= w_en;
      ref_q <= w_ref;
      ch_q  <= w_ch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_q  <= '0;
      refa_q <= 1'b0;
    end else if (app_en) begin
      mux_q  <= mux_n;
      refa_q <= refa_n;
    end
  end

  assign mux_sel = mux_q;
  assign ref_sel = refa_q;
  assign reg_rdata = {ch_q, busy, ref_q, en_q};
endmodule

// File: rtl/sar_approx_core.sv
module sar_approx_core
  import sar_pkg::*;
#(
  parameter int unsigned RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic                abort,
  input  logic                tick,
  input  logic                cmp_in,
  output logic                busy,
  output logic                sh_track,
  output logic [RES_BITS-1:0] dac_code,
  output logic [RES_BITS-1:0] result,
  output logic                done
);
  localparam int unsigned IW = (RES_BITS > 1) ? $clog2(RES_BITS) : 1;
  localparam logic [IW-1:0] TOP_IDX = IW'(RES_BITS - 1);

  sar_state_e          st_q, st_n;
  logic [IW-1:0]       idx_q, idx_n;
  logic [RES_BITS-1:0] acc_q, acc_n;
  logic [RES_BITS-1:0] res_q, res_n;
  logic                done_q, done_n;
  logic [RES_BITS-1:0] bit_mask, trial;
  logic                res_en;

  always_comb begin
    bit_mask = '0;
    for (int i = 0; i < RES_BITS; i++)
      if (idx_q == IW'(i)) bit_mask[i] = 1'b1;
  end

  assign trial = acc_q | bit_mask;

  always_comb begin
    st_n   = st_q;
    idx_n  = idx_q;
    acc_n  = acc_q;
    res_n  = res_q;
    res_en = 1'b0;
    done_n = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (go) begin
          st_n  = ST_SAMPLE;
          acc_n = '0;
        end
      end
      ST_SAMPLE: begin
        if (abort) st_n = ST_IDLE;
        else if (tick) begin
          st_n  = ST_BITS;
          idx_n = TOP_IDX;
        end
      end
      ST_BITS: begin
        if (abort) st_n = ST_IDLE;
        else if (tick) begin
          acc_n = cmp_in ? trial : acc_q;
          if (idx_q == '0) begin
            st_n   = ST_IDLE;
            res_n  = acc_n;
            res_en = 1'b1;
            done_n = 1'b1;
          end else begin
            idx_n = idx_q - IW'(1);
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      idx_q  <= idx_n;
      acc_q  <= acc_n;
      done_q <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_n;
  end

  assign busy     = (st_q != ST_IDLE);
  assign sh_track = (st_q == ST_SAMPLE);
  assign dac_code = (st_q == ST_BITS) ? trial : '0;
  assign result   = res_q;
  assign done     = done_q;
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int unsigned RES_BITS = 10,
  parameter int unsigned CH_BITS  = 2,
  parameter int unsigned DIV      = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [CH_BITS+2:0]  reg_wdata,
  output logic [CH_BITS+2:0]  reg_rdata,
  input  logic                cmp_in,
  output logic [CH_BITS-1:0]  mux_sel,
  output logic                ref_sel,
  output logic                sh_track,
  output logic [RES_BITS-1:0] dac_code,
  output logic [RES_BITS-1:0] result,
  output logic                done
);
  logic busy, go, abort, tick;

  sar_cfg_regs #(.CH_BITS(CH_BITS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .busy(busy), .reg_rdata(reg_rdata), .mux_sel(mux_sel),
    .ref_sel(ref_sel), .go(go), .abort(abort)
  );

  sar_prescaler #(.DIV(DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr(go), .run(busy), .tick(tick)
  );

  sar_approx_core #(.RES_BITS(RES_BITS)) u_core (
    .clk(clk), .rst_n(rst_n), .go(go), .abort(abort), .tick(tick),
    .cmp_in(cmp_in), .busy(busy), .sh_track(sh_track),
    .dac_code(dac_code), .result(result), .done(done)
  );
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int unsigned RES_BITS = 10,
  parameter int unsigned CH_BITS  = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [CH_BITS+2:0]  reg_rdata,
  input logic [CH_BITS-1:0]  mux_sel,
  input logic                sh_track,
  input logic [RES_BITS-1:0] dac_code,
  input logic                done
);
  logic start_rb, en_rb;
  assign start_rb = reg_rdata[2];
  assign en_rb    = reg_rdata[0];

  // R4
  done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_clears_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!start_rb && $past(start_rb)));

  // R7
  chan_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rb && $past(start_rb)) |-> $stable(mux_sel));

  // R8
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_rb |-> !start_rb);

  // R11
  track_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_track |-> start_rb);

  // R3
  dac_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_rb || sh_track) |-> (dac_code == '0));
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.RES_BITS(RES_BITS), .CH_BITS(CH_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .mux_sel(mux_sel),
  .sh_track(sh_track), .dac_code(dac_code), .done(done)
);

// File: tb/sar_conv_seq_bench.sv
`timescale 1ns/1ps
module sar_conv_seq_bench;
  localparam int RB  = 10;
  localparam int CB  = 2;
  localparam int DV  = 3;
  localparam int LAT = 11 * DV;

  logic          clk, rst_n, reg_we, cmp_in, ref_sel, sh_track, done;
  logic [CB+2:0] reg_wdata, reg_rdata;
  logic [CB-1:0] mux_sel;
  logic [RB-1:0] dac_code, result;

  logic [RB-1:0] vin_sup [4];
  logic [RB-1:0] vin_bg  [4];

  int n_run = 0;
  int n_bad = 0;

  sar_conv_seq #(.RES_BITS(RB), .CH_BITS(CB), .DIV(DV)) u_sar_conv_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cmp_in(cmp_in), .mux_sel(mux_sel),
    .ref_sel(ref_sel), .sh_track(sh_track), .dac_code(dac_code),
    .result(result), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [RB-1:0] level(input logic [CB-1:0] ch, input logic r);
    return r ? vin_bg[ch] : vin_sup[ch];
  endfunction

  assign cmp_in = (level(mux_sel, ref_sel) >= dac_code);

  function automatic logic [CB+2:0] mk(input logic [CB-1:0] ch, input logic st,
                                       input logic r, input logic en);
    return {ch, st, r, en};
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [CB+2:0] d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // started by the caller's write; now at the first negedge after the accepting edge
  task automatic run_conv(input int exp, input string tag);
    chk(reg_rdata[2] == 1'b1, "R5", reg_rdata[2], 1);
    for (int n = 0; n <= LAT; n++) begin
      if (n > 0) @(negedge clk);
      if (n < DV) chk(sh_track == 1'b1, "R11", sh_track, 1);
      else        chk(sh_track == 1'b0, "R11", sh_track, 0);
      if (n == DV) chk(dac_code == 10'd512, "R3", dac_code, 512);
      chk(done == (n == LAT), "R4", done, n == LAT);
      if (n == LAT) begin
        chk(result == exp, tag, result, exp);
        chk(reg_rdata[2] == 1'b0, "R5", reg_rdata[2], 0);
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R4", done, 0);
  endtask

  initial begin : watchdog
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4242));
    rst_n = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    for (int i = 0; i < 4; i++) begin
      vin_sup[i] = RB'(100 * i + 37);
      vin_bg[i]  = RB'(900 - 50 * i);
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(reg_rdata == '0 && done == 0 && sh_track == 0 && mux_sel == 0 &&
        ref_sel == 0 && dac_code == 0, "R1", reg_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 disabled: start and settings ignored
    wr(mk(2'd3, 1'b1, 1'b1, 1'b0));
    chk(reg_rdata[2] == 0 && sh_track == 0, "R8", reg_rdata[2], 0);
    chk(mux_sel == 0 && ref_sel == 0, "R8", {ref_sel, mux_sel}, 0);
    repeat (5) @(negedge clk);
    chk(done == 0 && result == 0, "R8", done, 0);

    // R6 start written as 0 while idle
    wr(mk(2'd1, 1'b0, 1'b0, 1'b1));
    repeat (2) @(negedge clk);
    chk(reg_rdata[2] == 0 && sh_track == 0, "R6", reg_rdata[2], 0);
    chk(mux_sel == 2'd1, "R10", mux_sel, 1);

    // R2 basic conversion, supply reference
    wr(mk(2'd1, 1'b1, 1'b0, 1'b1));
    run_conv(vin_sup[1], "R2");

    // R10 internal reference
    wr(mk(2'd2, 1'b0, 1'b1, 1'b1));
    @(negedge clk);
    chk(ref_sel == 1'b1, "R10", ref_sel, 1);
    wr(mk(2'd2, 1'b1, 1'b1, 1'b1));
    run_conv(vin_bg[2], "R10");

    // R2 corner codes
    vin_sup[0] = '0; vin_sup[3] = '1;
    wr(mk(2'd0, 1'b1, 1'b0, 1'b1));
    run_conv(0, "R2");
    wr(mk(2'd3, 1'b1, 1'b0, 1'b1));
    run_conv(1023, "R2");

    // R7 channel change mid-conversion (also R6: start=0 while busy)
    vin_sup[0] = 10'd321; vin_sup[2] = 10'd654;
    wr(mk(2'd0, 1'b1, 1'b0, 1'b1));
    repeat (2 * DV) @(negedge clk);
    wr(mk(2'd2, 1'b0, 1'b0, 1'b1));
    chk(reg_rdata[2] == 1'b1, "R6", reg_rdata[2], 1);
    chk(mux_sel == 2'd0, "R7", mux_sel, 0);
    while (!done) @(negedge clk);
    chk(result == 10'd321, "R7", result, 321);
    @(negedge clk);
    chk(mux_sel == 2'd2, "R7", mux_sel, 2);
    wr(mk(2'd2, 1'b1, 1'b0, 1'b1));
    run_conv(654, "R7");

    // R9 abort by clearing enable
    wr(mk(2'd1, 1'b1, 1'b0, 1'b1));
    repeat (4 * DV) @(negedge clk);
    wr(mk(2'd1, 1'b0, 1'b0, 1'b0));
    chk(reg_rdata[2] == 1'b0, "R9", reg_rdata[2], 0);
    begin
      int seen = 0;
      for (int n = 0; n < LAT + 4; n++) begin
        @(negedge clk);
        if (done) seen++;
      end
      chk(seen == 0, "R9", seen, 0);
      chk(result == 654, "R9", result, 654);
    end

    // random conversions on both references
    for (int k = 0; k < 30; k++) begin
      logic [CB-1:0] ch;
      logic r;
      ch = CB'($urandom_range(0, 3));
      r  = 1'($urandom_range(0, 1));
      vin_sup[ch] = RB'($urandom);
      vin_bg[ch]  = RB'($urandom);
      wr(mk(ch, 1'b1, r, 1'b1));
      run_conv(level(ch, r), "R2");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule